// File: doc/BRIEF.md
# Channel Fault Flag Keeper

This block keeps a sticky fault record for a bank of low-side output channels. Each channel has two flags. An overcurrent flag is raised when the channel's comparator reports excess current while the channel is commanded on. An open-load flag is raised when the load-sense comparator reports a low pin level while the channel is commanded off. Raw comparator levels and the thermal-shutdown level are asynchronous to the clock, so each passes through a two-flop synchronizer before any flag logic sees it.

An overcurrent flag forces its channel off until the channel's drive bit is returned to 0. An open-load flag clears when the drive bit returns to 1. A bulk-clear strobe wipes every flag at once. An active-low fault pin stays asserted while any flag is set or the die is too hot. Thermal shutdown disables every output and recovers by itself once the condition goes away. An undervoltage level resets all internal state and disables the outputs, and it keeps the fault pin released.

The full flag word is presented for serial readback. Overcurrent flags sit in the upper half and open-load flags in the lower half. A parameter can remove open-load sensing entirely.

Top module: `chan_fault_keeper`

## Requirements
- R1: `fault_word_o` is 2×NUM_CH bits wide. Bit NUM_CH+i is the overcurrent flag of channel i, and bit i is its open-load flag (channel 0 is the lowest). After reset, every bit is 0, `fault_n_o` is 1, `all_off_o` is 0 and `chan_block_o` is 0.
- R2: An overcurrent flag sets at the third rising edge after its raw comparator input rises. It sets only if the channel's drive bit is 1 and `all_off_o` is 0 at that edge. It stays set after the comparator falls.
- R3: `chan_block_o[i]` is 1 exactly while the overcurrent flag of channel i is set, and `fault_n_o` is then 0.
- R4: An overcurrent flag clears at the first rising edge at which the channel's drive bit is 0.
- R5: An open-load flag sets at the third rising edge after its raw comparator input rises, and only while the channel's drive bit is 0. It stays set after the comparator falls.
- R6: An open-load flag clears at the first rising edge at which the channel's drive bit is 1.
- R7: A `clr_all_i` pulse sampled at a rising edge leaves every bit of `fault_word_o` at 0 after that edge.
- R8: Outside undervoltage, `fault_n_o` is 0 whenever any flag is set or the synchronized thermal input is 1. Otherwise it is 1, so it is released once all flags are 0.
- R9: While the synchronized thermal input is 1, `all_off_o` is 1 and no overcurrent flag can set. Both `all_off_o` and `fault_n_o` return to 0 and 1 without help once the thermal input falls, two edges later.
- R10: While `uv_lock_i` is 1, `all_off_o` is 1 and `fault_n_o` is 1. Every flag and synchronizer stage is cleared at each edge in that state.
- R11: With HAS_OPEN_LOAD = 0, bits NUM_CH-1..0 of `fault_word_o` always read 0, and the overcurrent flags behave as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_lock_i | input | 1 | Undervoltage level; clears all state and disables outputs |
| hot_raw_i | input | 1 | Asynchronous thermal-shutdown level |
| ovc_raw_i | input | NUM_CH | Asynchronous overcurrent comparator levels |
| olo_raw_i | input | NUM_CH | Asynchronous open-load comparator levels |
| drive_req_i | input | NUM_CH | Commanded on/off state per channel (1 = on) |
| clr_all_i | input | 1 | Bulk flag clear strobe |
| fault_word_o | output | 2*NUM_CH | Flag word: overcurrent flags high, open-load flags low |
| chan_block_o | output | NUM_CH | Per-channel forced-off |
| all_off_o | output | 1 | Global output disable |
| fault_n_o | output | 1 | Active-low fault pin |

## Verification
The main flag path is swept over a grid of drive patterns crossed with comparator patterns. The drive patterns are all-off, all-on and two mixed patterns; the comparator patterns are none, all and two sparse ones. In each combination, the overcurrent flags must follow comparator AND drive, and the open-load flags must follow comparator AND NOT drive. This shows whether the arming condition of each flag type uses the correct drive polarity. Each grid point is then checked three ways: held after the comparators drop, which tests stickiness; cleared after the drive pattern is inverted, which tests the opposite-transition clear; and the fault pin released only once the word is zero. Separate sequences cover the bulk clear, thermal shutdown with overcurrent attempted during it, undervoltage with a hot die, and a second instance built without open-load sensing.

// File: rtl/cfk_pkg.sv
package cfk_pkg;

    localparam int unsigned CFK_SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_DROP = 2'd2
    } flag_act_e;

    typedef struct packed {
        logic shut;   // outputs disabled
        logic quiet;  // fault pin forced released
    } gate_t;

    // Decide what one sticky flag does at the next edge.
    function automatic flag_act_e pick_act(
        input logic wipe,
        input logic keep,
        input logic hit,
        input logic arm
    );
        if (wipe || !keep)
            return ACT_DROP;
        else if (hit && arm)
            return ACT_SET;
        else
            return ACT_HOLD;
    endfunction

    function automatic logic apply_act(input flag_act_e act, input logic cur);
        case (act)
            ACT_SET:  return 1'b1;
            ACT_DROP: return 1'b0;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/cfk_sync.sv
module cfk_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             wipe,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (wipe) chain[s] <= '0;
                    else      chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (wipe) chain[s] <= '0;
                    else      chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfk_flag_bank.sv
module cfk_flag_bank
    import cfk_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              clr_all,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] arm,
    input  logic [NUM_CH-1:0] keep,
    output logic [NUM_CH-1:0] flags_o
);
    logic [NUM_CH-1:0] flags_q;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            flag_act_e act;
            always_comb act = pick_act(wipe || clr_all, keep[i], hit[i], arm[i]);

            always_ff @(posedge clk) begin
                flags_q[i] <= apply_act(act, flags_q[i]);
            end

            AST_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
                $rose(flags_q[i]) |-> $past(arm[i] && hit[i])); // R2 R5

            AST_DROP_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
                !keep[i] |=> !flags_q[i]); // R4 R6
        end
    endgenerate

    assign flags_o = flags_q;
endmodule

// File: rtl/chan_fault_keeper.sv
module chan_fault_keeper
    import cfk_pkg::*;
#(
    parameter int unsigned NUM_CH        = 8,
    parameter bit          HAS_OPEN_LOAD = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                uv_lock_i,
    input  logic                hot_raw_i,
    input  logic [NUM_CH-1:0]   ovc_raw_i,
    input  logic [NUM_CH-1:0]   olo_raw_i,
    input  logic [NUM_CH-1:0]   drive_req_i,
    input  logic                clr_all_i,
    output logic [2*NUM_CH-1:0] fault_word_o,
    output logic [NUM_CH-1:0]   chan_block_o,
    output logic                all_off_o,
    output logic                fault_n_o
);
    localparam int unsigned SYNC_W = 2 * NUM_CH + 1;

    logic              wipe;
    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic [NUM_CH-1:0] ovc_s, olo_s, ovc_flags, olo_flags;
    logic              hot_s;
    gate_t             gate;

    assign wipe    = rst || uv_lock_i;
    assign raw_bus = {hot_raw_i, olo_raw_i, ovc_raw_i};

    cfk_sync #(.WIDTH(SYNC_W), .STAGES(CFK_SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .wipe (wipe),
        .d_i  (raw_bus),
        .q_o  (syn_bus)
    );

    assign ovc_s = syn_bus[NUM_CH-1:0];
    assign olo_s = syn_bus[2*NUM_CH-1:NUM_CH];
    assign hot_s = syn_bus[SYNC_W-1];

    assign gate.shut  = hot_s || uv_lock_i;
    assign gate.quiet = uv_lock_i;

    cfk_flag_bank #(.NUM_CH(NUM_CH)) u_ovc_bank (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .clr_all (clr_all_i),
        .hit     (ovc_s),
        .arm     (drive_req_i & {NUM_CH{!gate.shut}}),
        .keep    (drive_req_i),
        .flags_o (ovc_flags)
    );

    generate
        if (HAS_OPEN_LOAD) begin : g_ol
            cfk_flag_bank #(.NUM_CH(NUM_CH)) u_olo_bank (
                .clk     (clk),
                .rst     (rst),
                .wipe    (wipe),
                .clr_all (clr_all_i),
                .hit     (olo_s),
                .arm     (~drive_req_i),
                .keep    (~drive_req_i),
                .flags_o (olo_flags)
            );
        end else begin : g_no_ol
            assign olo_flags = '0;
        end
    endgenerate

    assign fault_word_o = {ovc_flags, olo_flags};
    assign chan_block_o = ovc_flags;
    assign all_off_o    = gate.shut;
    assign fault_n_o    = gate.quiet || !((|fault_word_o) || hot_s);

    AST_BULK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_all_i |=> (fault_word_o == '0)); // R7

    AST_PIN_WITH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!uv_lock_i && (fault_word_o != '0)) |-> !fault_n_o); // R8

    AST_BLOCK_PULLS_PIN: assert property (@(posedge clk) disable iff (rst)
        (!uv_lock_i && (chan_block_o != '0)) |-> !fault_n_o); // R3

    AST_UV_SILENT: assert property (@(posedge clk) disable iff (rst)
        uv_lock_i |-> (fault_n_o && all_off_o)); // R10

    AST_UV_WIPES: assert property (@(posedge clk) disable iff (rst)
        uv_lock_i |=> (fault_word_o == '0)); // R10
endmodule

// File: tb/chan_fault_keeper_tb.sv
module chan_fault_keeper_tb;
    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         uv = 1'b0, hot = 1'b0, clr = 1'b0;
    logic [N-1:0] ovc = '0, olo = '0, drv = '0;
    logic [2*N-1:0] word, word_nol;
    logic [N-1:0] blk, blk_nol;
    logic         off, off_nol, fn, fn_nol;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    chan_fault_keeper #(.NUM_CH(N), .HAS_OPEN_LOAD(1'b1)) u_dut (
        .clk(clk), .rst(rst), .uv_lock_i(uv), .hot_raw_i(hot),
        .ovc_raw_i(ovc), .olo_raw_i(olo), .drive_req_i(drv), .clr_all_i(clr),
        .fault_word_o(word), .chan_block_o(blk), .all_off_o(off), .fault_n_o(fn)
    );

    chan_fault_keeper #(.NUM_CH(N), .HAS_OPEN_LOAD(1'b0)) u_dut_nol (
        .clk(clk), .rst(rst), .uv_lock_i(uv), .hot_raw_i(hot),
        .ovc_raw_i(ovc), .olo_raw_i(olo), .drive_req_i(drv), .clr_all_i(clr),
        .fault_word_o(word_nol), .chan_block_o(blk_nol), .all_off_o(off_nol), .fault_n_o(fn_nol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] dpat [4];
        logic [N-1:0] cpat [4];
        logic [2*N-1:0] e;
        dpat = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        cpat = '{8'h00, 8'hFF, 8'h5A, 8'h81};

        step(2);
        rst = 1'b0;
        step(1);
        chk("R1 reset word", 32'(word), 32'h0);
        chk("R1 reset pin", 32'(fn), 32'h1);
        chk("R1 reset off", 32'(off), 32'h0);
        chk("R1 reset block", 32'(blk), 32'h0);

        // Grid sweep: R2 R3 R4 R5 R6 R8 R11
        for (int di = 0; di < 4; di++) begin
            for (int ci = 0; ci < 4; ci++) begin
                drv = dpat[di];
                ovc = cpat[ci];
                olo = cpat[ci];
                e = {cpat[ci] & dpat[di], cpat[ci] & ~dpat[di]};
                step(2);
                chk("R2 R5 not before third edge", 32'(word), 32'h0);
                step(1);
                chk("R2 R5 flags set", 32'(word), 32'(e));
                chk("R3 block", 32'(blk), 32'(cpat[ci] & dpat[di]));
                chk("R8 pin", 32'(fn), 32'(e == '0));
                chk("R11 no open-load", 32'(word_nol), 32'({cpat[ci] & dpat[di], 8'h00}));
                ovc = '0;
                olo = '0;
                step(3);
                chk("R2 R5 sticky", 32'(word), 32'(e));
                drv = ~dpat[di];
                step(1);
                chk("R4 R6 opposite clear", 32'(word), 32'h0);
                chk("R8 pin released", 32'(fn), 32'h1);
                chk("R11 clear", 32'(word_nol), 32'h0);
            end
        end

        // R7 bulk clear
        drv = 8'h0F;
        ovc = 8'hFF;
        olo = 8'hFF;
        step(3);
        chk("R7 preload", 32'(word), 32'h0FF0);
        ovc = '0;
        olo = '0;
        step(3);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        chk("R7 cleared", 32'(word), 32'h0);
        chk("R7 pin", 32'(fn), 32'h1);

        // R9 thermal
        drv = 8'hFF;
        hot = 1'b1;
        step(1);
        chk("R9 not yet off", 32'(off), 32'h0);
        step(1);
        chk("R9 off", 32'(off), 32'h1);
        chk("R9 pin", 32'(fn), 32'h0);
        ovc = 8'hFF;
        step(3);
        chk("R9 no overcurrent while hot", 32'(word), 32'h0);
        ovc = '0;
        step(3);
        hot = 1'b0;
        step(2);
        chk("R9 recovered off", 32'(off), 32'h0);
        chk("R9 recovered pin", 32'(fn), 32'h1);

        // R10 undervoltage
        drv = 8'h00;
        olo = 8'h33;
        hot = 1'b1;
        step(3);
        chk("R10 preload", 32'(word), 32'h0033);
        olo = '0;
        uv = 1'b1;
        #1;
        chk("R10 pin quiet", 32'(fn), 32'h1);
        chk("R10 off", 32'(off), 32'h1);
        step(1);
        chk("R10 wiped", 32'(word), 32'h0);
        step(3);
        chk("R10 pin quiet while hot", 32'(fn), 32'h1);
        hot = 1'b0;
        step(1);
        uv = 1'b0;
        step(3);
        chk("R10 released off", 32'(off), 32'h0);
        chk("R10 released pin", 32'(fn), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule